// File: doc/BRIEF.md
# Caption Capture Status Register Bank

This block holds the caption and wide-screen-signalling bytes that a video data slicer recovers from the odd and even fields, and exposes them to a host through a byte-wide register port with an 8-bit sub-address. A slicer hands over a 16-bit payload together with its field, its data type (caption or WSS) and the video line it came from. The bank keeps four byte pairs: odd caption, even caption, odd WSS and even WSS. A sticky new-data flag for each pair is set when fresh data lands. The flag clears when the host reads the second byte of the pair, or when an ancillary-packet emitter reports that it has sent that pair.

A control/status byte at 1Fh carries the four flags, a power-down bit and a self-clearing soft-reset bit. The power-down bit drives a clock-stop output for the rest of the device, while the register port itself keeps working. The soft-reset bit puts the whole bank back to its reset state, exactly as the reset pin does.

Top module: `caption_status_bank`

## Requirements
- R1: After reset, sub-addresses 20h-23h (caption bytes) read 80h, 24h-27h (WSS bytes) read 00h, and the status byte at 1Fh reads 00h.
- R2: An accepted capture loads payload bits 7:0 into the first byte and bits 15:8 into the second byte of its pair, and sets that pair's flag. The pairs are: odd caption at 20h/21h with status bit 5, even caption at 22h/23h with bit 4, odd WSS at 24h/25h with bit 3, and even WSS at 26h/27h with bit 2. Field input 0 means odd and 1 means even. Kind input 0 means caption and 1 means WSS. The result is readable from the first clock edge after the strobe. WSS captures are accepted from any line.
- R3: A caption capture is accepted only from lines 18, 21 or 22 in the odd field, and from lines 281, 284 or 335 in the even field. A caption capture on any other line changes nothing.
- R4: A caption capture is accepted only while captioning is enabled for its field. A capture arriving while that enable is low changes nothing.
- R5: Host writes to 20h-27h and to status bits 5:2 have no effect.
- R6: A host read strobe on a pair's second byte (odd address) clears that pair's flag at the edge. A read of the first byte leaves the flag set.
- R7: An ancillary-sent strobe with a 2-bit pair selector clears only the selected flag. Selector 0 selects odd caption, 1 selects even caption, 2 selects odd WSS and 3 selects even WSS.
- R8: If a capture and a clearing event hit the same pair in the same cycle, the capture wins and the flag stays set.
- R9: Status bit 6 is host-writable and reads back, and the clock-stop output equals it.
- R10: Writing 1 to status bit 7 makes bit 7 read 1 and the soft-reset output go high for one cycle. On the following edge every register returns to its R1 value, and bit 7 returns to 0.
- R11: A read of an unmapped sub-address returns 00h and clears no flag.
- R12: Status bits 1:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Register sub-address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe (drives read side effects) |
| host_rdata | output | 8 | Read data for host_addr |
| cap_valid | input | 1 | Capture strobe from the slicer |
| cap_field | input | 1 | 0 odd field, 1 even field |
| cap_kind | input | 1 | 0 caption, 1 WSS |
| cap_line | input | 9 | Video line of the capture |
| cap_data | input | 16 | Payload, bit 0 earliest |
| cc_odd_en | input | 1 | Odd-field captioning enable |
| cc_even_en | input | 1 | Even-field captioning enable |
| anc_sent | input | 1 | Ancillary emission done strobe |
| anc_sel | input | 2 | Pair that was emitted |
| clk_stop | output | 1 | Clock-gate disable for the device |
| soft_rst_out | output | 1 | Soft reset in progress |

## Verification
Read data is combinational from the address, so a peek is sampled one time unit after the bench drives the address, in the same cycle. Captures, clears and writes take effect at the first rising edge after the strobe. The bench therefore drives each strobe on a falling edge, removes it on the next falling edge and samples from there on. The soft reset is due one edge later than other writes: bit 7 is checked in the cycle after the write, and the reset values in the cycle after that.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int PAIRS     = 4;
  localparam int PIDX_W    = $clog2(PAIRS);
  localparam int LINE_W    = 9;
  localparam int PAYLOAD_W = 2 * DATA_W;
  localparam int LINE_SETS = 3;

  localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'h1F;
  localparam logic [ADDR_W-1:0] DATA_BASE   = 8'h20;

  localparam logic [DATA_W-1:0] CC_RST_VAL  = 8'h80;
  localparam logic [DATA_W-1:0] WSS_RST_VAL = 8'h00;

  // status byte layout
  localparam int BIT_SRST    = 7;
  localparam int BIT_PD      = 6;
  localparam int BIT_FLAG_HI = 5;

  typedef enum logic [PIDX_W-1:0] {
    PAIR_CC_ODD   = 2'd0,
    PAIR_CC_EVEN  = 2'd1,
    PAIR_WSS_ODD  = 2'd2,
    PAIR_WSS_EVEN = 2'd3
  } pair_e;

  typedef enum logic { FLD_ODD = 1'b0, FLD_EVEN = 1'b1 } field_e;
  typedef enum logic { KIND_CC = 1'b0, KIND_WSS = 1'b1 } kind_e;
endpackage

// File: rtl/ccs_rst_sync.sv
module ccs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ccs_capture_decode.sv
module ccs_capture_decode
  import ccs_pkg::*;
#(
  parameter logic [LINE_W-1:0] ODD_LINES  [LINE_SETS] = '{9'd18, 9'd21, 9'd22},
  parameter logic [LINE_W-1:0] EVEN_LINES [LINE_SETS] = '{9'd281, 9'd284, 9'd335}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic              cap_field,
  input  logic              cap_kind,
  input  logic [LINE_W-1:0] cap_line,
  input  logic              cc_odd_en,
  input  logic              cc_even_en,
  output logic [PAIRS-1:0]  hit
);
  logic [LINE_SETS-1:0] odd_match;
  logic [LINE_SETS-1:0] even_match;

  for (genvar i = 0; i < LINE_SETS; i++) begin : g_line
    assign odd_match[i]  = (cap_line == ODD_LINES[i]);
    assign even_match[i] = (cap_line == EVEN_LINES[i]);
  end

  logic is_odd, is_cc;
  assign is_odd = (cap_field == FLD_ODD);
  assign is_cc  = (cap_kind == KIND_CC);

  always_comb begin
    hit = '0;
    hit[PAIR_CC_ODD]   = cap_valid &  is_cc &  is_odd & cc_odd_en  & (|odd_match);
    hit[PAIR_CC_EVEN]  = cap_valid &  is_cc & !is_odd & cc_even_en & (|even_match);
    hit[PAIR_WSS_ODD]  = cap_valid & !is_cc &  is_odd;
    hit[PAIR_WSS_EVEN] = cap_valid & !is_cc & !is_odd;
  end

  p_one_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  p_odd_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit[PAIR_CC_ODD] |-> (cap_line == 9'd18 || cap_line == 9'd21 || cap_line == 9'd22));
  p_even_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit[PAIR_CC_EVEN] |-> (cap_line == 9'd281 || cap_line == 9'd284 || cap_line == 9'd335));
  p_cc_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cc_odd_en && !cc_even_en) |-> !hit[PAIR_CC_ODD] && !hit[PAIR_CC_EVEN]);
endmodule

// File: rtl/ccs_pair_reg.sv
module ccs_pair_reg
  import ccs_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              cap_hit,
  input  logic [DATA_W-1:0] cap_a,
  input  logic [DATA_W-1:0] cap_b,
  input  logic              clr,
  output logic [DATA_W-1:0] byte_a,
  output logic [DATA_W-1:0] byte_b,
  output logic              flag
);
  logic [DATA_W-1:0] a_d, b_d;
  logic              flag_d;
  logic              data_en;

  assign data_en = cap_hit | srst;

  always_comb begin
    a_d    = byte_a;
    b_d    = byte_b;
    flag_d = flag;
    if (srst) begin
      a_d    = RST_VAL;
      b_d    = RST_VAL;
      flag_d = 1'b0;
    end else if (cap_hit) begin
      a_d    = cap_a;
      b_d    = cap_b;
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_a <= RST_VAL;
      byte_b <= RST_VAL;
    end else if (data_en) begin
      byte_a <= a_d;
      byte_b <= b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hit && !srst) |=> flag);
  p_capture_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_hit && clr && !srst) |=> flag);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cap_hit) |=> !flag);
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_hit && !srst) |=> ($stable(byte_a) && $stable(byte_b)));
endmodule

// File: rtl/ccs_ctrl_reg.sv
module ccs_ctrl_reg
  import ccs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic pd_in,
  input  logic srst_in,
  output logic pd,
  output logic srst_req
);
  logic pd_d, srst_d;

  always_comb begin
    pd_d   = pd;
    srst_d = 1'b0;
    if (srst_req) begin
      pd_d   = 1'b0;
    end else if (wr_en) begin
      pd_d   = pd_in;
      srst_d = srst_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd       <= 1'b0;
      srst_req <= 1'b0;
    end else begin
      pd       <= pd_d;
      srst_req <= srst_d;
    end
  end

  p_srst_self_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |=> !srst_req);
  p_pd_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |=> !pd);
endmodule

// File: rtl/caption_status_bank.sv
module caption_status_bank
  import ccs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  host_addr,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  input  logic        host_rd,
  output logic [7:0]  host_rdata,
  input  logic        cap_valid,
  input  logic        cap_field,
  input  logic        cap_kind,
  input  logic [8:0]  cap_line,
  input  logic [15:0] cap_data,
  input  logic        cc_odd_en,
  input  logic        cc_even_en,
  input  logic        anc_sent,
  input  logic [1:0]  anc_sel,
  output logic        clk_stop,
  output logic        soft_rst_out
);
  logic rst_sync_n;
  logic pd, srst_req;
  logic [PAIRS-1:0] hit, clr, flag, sel_a, sel_b;
  logic [DATA_W-1:0] byte_a [PAIRS];
  logic [DATA_W-1:0] byte_b [PAIRS];
  logic status_sel, status_wr;
  logic [DATA_W-1:0] status_byte;

  ccs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ccs_capture_decode u_dec (
    .clk(clk), .rst_n(rst_sync_n),
    .cap_valid(cap_valid), .cap_field(cap_field), .cap_kind(cap_kind),
    .cap_line(cap_line), .cc_odd_en(cc_odd_en), .cc_even_en(cc_even_en),
    .hit(hit)
  );

  assign status_sel = (host_addr == STATUS_ADDR);
  assign status_wr  = host_wr & status_sel;

  ccs_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(status_wr),
    .pd_in(host_wdata[BIT_PD]), .srst_in(host_wdata[BIT_SRST]),
    .pd(pd), .srst_req(srst_req)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam logic [DATA_W-1:0] RV = (p < 2) ? CC_RST_VAL : WSS_RST_VAL;
    localparam logic [ADDR_W-1:0] A_ADDR = DATA_BASE + ADDR_W'(2 * p);
    localparam logic [ADDR_W-1:0] B_ADDR = DATA_BASE + ADDR_W'(2 * p + 1);

    assign sel_a[p] = (host_addr == A_ADDR);
    assign sel_b[p] = (host_addr == B_ADDR);
    assign clr[p]   = (host_rd & sel_b[p]) |
                      (anc_sent & (anc_sel == PIDX_W'(p)));

    ccs_pair_reg #(.RST_VAL(RV)) u_pair (
      .clk(clk), .rst_n(rst_sync_n), .srst(srst_req),
      .cap_hit(hit[p]),
      .cap_a(cap_data[DATA_W-1:0]), .cap_b(cap_data[PAYLOAD_W-1:DATA_W]),
      .clr(clr[p]),
      .byte_a(byte_a[p]), .byte_b(byte_b[p]), .flag(flag[p])
    );
  end

  always_comb begin
    status_byte = '0;
    status_byte[BIT_SRST] = srst_req;
    status_byte[BIT_PD]   = pd;
    for (int p = 0; p < PAIRS; p++) begin
      status_byte[BIT_FLAG_HI - p] = flag[p];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (status_sel) host_rdata = status_byte;
    for (int p = 0; p < PAIRS; p++) begin
      if (sel_a[p]) host_rdata = byte_a[p];
      if (sel_b[p]) host_rdata = byte_b[p];
    end
  end

  assign clk_stop     = pd;
  assign soft_rst_out = srst_req;

  p_pd_write_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_wr && host_addr == 8'h1F && !srst_req) |=> (clk_stop == $past(host_wdata[6])));
  p_srst_clears_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_rst_out |=> (flag == '0 && !clk_stop));
  p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_addr == 8'h1F) |-> (host_rdata[1:0] == 2'b00));
  p_unmapped_keeps_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_rd && !anc_sent && !srst_req && (host_addr < 8'h1F || host_addr > 8'h27))
      |=> (flag == ($past(flag) | $past(hit))));
endmodule

// File: tb/caption_status_bank_test.sv
module caption_status_bank_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  op;    // 0 capture, 1 read strobe + check, 2 write, 3 peek
    logic        fld;
    logic        knd;
    logic [8:0]  line;
    logic [15:0] dat;
    logic [7:0]  addr;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VEC [NV] = '{
    '{2'd0,1'b0,1'b0,9'd21, 16'h5A12,8'h00,8'h00,4'd2},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h1F,8'h20,4'd2},
    '{2'd1,1'b0,1'b0,9'd0,  16'h0000,8'h20,8'h12,4'd6},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h1F,8'h20,4'd6},
    '{2'd1,1'b0,1'b0,9'd0,  16'h0000,8'h21,8'h5A,4'd6},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h1F,8'h00,4'd6},
    '{2'd0,1'b1,1'b0,9'd284,16'hC3B4,8'h00,8'h00,4'd2},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h1F,8'h10,4'd2},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h22,8'hB4,4'd2},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h23,8'hC3,4'd2},
    '{2'd0,1'b0,1'b1,9'd23, 16'h0F0E,8'h00,8'h00,4'd2},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h1F,8'h18,4'd2},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h24,8'h0E,4'd2},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h25,8'h0F,4'd2},
    '{2'd0,1'b1,1'b1,9'd100,16'h1234,8'h00,8'h00,4'd2},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h1F,8'h1C,4'd2},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h26,8'h34,4'd2},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h27,8'h12,4'd2},
    '{2'd0,1'b0,1'b0,9'd19, 16'hFFFF,8'h00,8'h00,4'd3},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h20,8'h12,4'd3},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h1F,8'h1C,4'd3},
    '{2'd0,1'b1,1'b0,9'd335,16'h0102,8'h00,8'h00,4'd3},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h22,8'h02,4'd3},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h23,8'h01,4'd3},
    '{2'd0,1'b1,1'b0,9'd21, 16'hEEEE,8'h00,8'h00,4'd3},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h22,8'h02,4'd3},
    '{2'd0,1'b0,1'b0,9'd18, 16'h7788,8'h00,8'h00,4'd3},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h20,8'h88,4'd3},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h21,8'h77,4'd3},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h1F,8'h3C,4'd3},
    '{2'd2,1'b0,1'b0,9'd0,  16'h00AA,8'h20,8'h00,4'd5},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h20,8'h88,4'd5},
    '{2'd2,1'b0,1'b0,9'd0,  16'h003F,8'h1F,8'h00,4'd12},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h1F,8'h3C,4'd12},
    '{2'd1,1'b0,1'b0,9'd0,  16'h0000,8'h30,8'h00,4'd11},
    '{2'd1,1'b0,1'b0,9'd0,  16'h0000,8'h05,8'h00,4'd11},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h1F,8'h3C,4'd11},
    '{2'd1,1'b0,1'b0,9'd0,  16'h0000,8'h27,8'h12,4'd6},
    '{2'd3,1'b0,1'b0,9'd0,  16'h0000,8'h1F,8'h38,4'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  host_addr;
  logic        host_wr;
  logic [7:0]  host_wdata;
  logic        host_rd;
  logic [7:0]  host_rdata;
  logic        cap_valid;
  logic        cap_field;
  logic        cap_kind;
  logic [8:0]  cap_line;
  logic [15:0] cap_data;
  logic        cc_odd_en;
  logic        cc_even_en;
  logic        anc_sent;
  logic [1:0]  anc_sel;
  logic        clk_stop;
  logic        soft_rst_out;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  caption_status_bank uut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .cap_valid(cap_valid), .cap_field(cap_field), .cap_kind(cap_kind),
    .cap_line(cap_line), .cap_data(cap_data),
    .cc_odd_en(cc_odd_en), .cc_even_en(cc_even_en),
    .anc_sent(anc_sent), .anc_sel(anc_sel),
    .clk_stop(clk_stop), .soft_rst_out(soft_rst_out)
  );

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge with inputs idle
  task automatic capture(input logic f, input logic k, input logic [8:0] ln,
                         input logic [15:0] d);
    cap_valid = 1'b1; cap_field = f; cap_kind = k; cap_line = ln; cap_data = d;
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, input logic [7:0] exp, input int req);
    host_addr = a;
    #1;
    check(req, host_rdata, exp, $sformatf("peek %02h", a));
    @(negedge clk);
  endtask

  task automatic read_strobe(input logic [7:0] a, input logic [7:0] exp, input int req);
    host_addr = a; host_rd = 1'b1;
    #1;
    check(req, host_rdata, exp, $sformatf("read %02h", a));
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic anc(input logic [1:0] s);
    anc_sent = 1'b1; anc_sel = s;
    @(negedge clk);
    anc_sent = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    host_addr = 8'h00; host_wr = 1'b0; host_wdata = 8'h00; host_rd = 1'b0;
    cap_valid = 1'b0; cap_field = 1'b0; cap_kind = 1'b0; cap_line = '0; cap_data = '0;
    cc_odd_en = 1'b1; cc_even_en = 1'b1; anc_sent = 1'b0; anc_sel = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    for (int a = 8'h20; a <= 8'h27; a++)
      peek(8'(a), (a < 8'h24) ? 8'h80 : 8'h00, 1);
    peek(8'h1F, 8'h00, 1);
    checks++;
    if (clk_stop !== 1'b0 || soft_rst_out !== 1'b0) begin
      failures++;
      $display("FAIL R1 outputs: actual %b%b expected 00", clk_stop, soft_rst_out);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: capture(VEC[i].fld, VEC[i].knd, VEC[i].line, VEC[i].dat);
        2'd1: read_strobe(VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
        2'd2: write_reg(VEC[i].addr, VEC[i].dat[7:0]);
        default: peek(VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
      endcase
    end

    // R7 ancillary clears only the selected flag (state 38h)
    anc(2'd1);
    peek(8'h1F, 8'h28, 7);
    anc(2'd2);
    peek(8'h1F, 8'h20, 7);

    // R4 capture with the field's enable low
    read_strobe(8'h21, 8'h77, 6);
    peek(8'h1F, 8'h00, 6);
    cc_odd_en = 1'b0;
    capture(1'b0, 1'b0, 9'd21, 16'h9999);
    peek(8'h20, 8'h88, 4);
    peek(8'h1F, 8'h00, 4);
    cc_odd_en = 1'b1;

    // R8 capture and clearing read in the same cycle
    cap_valid = 1'b1; cap_field = 1'b0; cap_kind = 1'b0; cap_line = 9'd22;
    cap_data = 16'h4321; host_addr = 8'h21; host_rd = 1'b1;
    @(negedge clk);
    cap_valid = 1'b0; host_rd = 1'b0;
    peek(8'h1F, 8'h20, 8);
    peek(8'h21, 8'h43, 8);

    // R9 power down
    write_reg(8'h1F, 8'h40);
    host_addr = 8'h1F; #1;
    check(9, {7'd0, clk_stop}, 8'h01, "clk_stop high");
    peek(8'h1F, 8'h60, 9);

    // R10 soft reset
    write_reg(8'h1F, 8'hC0);
    host_addr = 8'h1F; #1;
    check(10, host_rdata, 8'hE0, "bit7 visible");
    check(10, {7'd0, soft_rst_out}, 8'h01, "soft_rst_out high");
    @(negedge clk);
    peek(8'h1F, 8'h00, 10);
    check(10, {6'd0, clk_stop, soft_rst_out}, 8'h00, "outputs after soft reset");
    peek(8'h20, 8'h80, 10);
    peek(8'h23, 8'h80, 10);
    peek(8'h26, 8'h00, 10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule